// File: doc/BRIEF.md
# Debug Emulation Opcode Sequencer

This block drives a stack-machine processor core that has been halted in emulation (debug) mode. A debugger presents one high-level command at a time: fetch a memory word, store a memory word, read the stack pointer, load a new program counter, or single-step. The sequencer expands each command into an ordered program of 8-bit opcodes and feeds them to the core one at a time. Each opcode is placed on the instruction output one cycle before a single-cycle execute strobe. A fixed settling interval then passes before the next opcode is issued.

Memory and program-counter access use only injected opcodes. A 32-bit operand is split into five chained immediate opcodes. Memory accesses save the stack context first and restore it afterwards. The sequencer compares the stack pointer it captured at the start with the value seen after the restore, and flags any difference. Read results are taken from the core's top-of-stack debug output and returned with a one-cycle valid pulse.

Top module: `dbg_opseq`

## Requirements
- R1: During and right after reset, `emu_ir` is 0x0B (NOP), `emu_exec`, `emu_req`, `rsp_valid` and `sp_err` are 0, `rsp_data` is 0, and `cmd_ready` is 1.
- R2: Opcode issue follows a fixed pattern. `emu_ir` takes the new opcode in cycle t. `emu_exec` is 1 in cycle t+1 only. `emu_ir` then holds for SETTLE_CYC further cycles before it can change again.
- R3: `emu_req` rises on the first accepted command and never falls afterwards. No opcode is placed on `emu_ir` unless `emu_ack` and `emu_rdy` were both 1 in the cycle before.
- R4: A 32-bit value V goes out as five opcodes: {1'b1,3'b000,V[31:28]}, {1'b1,V[27:21]}, {1'b1,V[20:14]}, {1'b1,V[13:7]}, {1'b1,V[6:0]}.
- R5: Command code 0 (memory read) issues 0x02, imm(addr), 0x08, 0x0B, 0x71, 0x0D, 0x0B. `core_tos` is sampled in the last settle cycle of the first 0x0B.
- R6: Command code 1 (memory write) issues 0x02, imm(data), 0x0B, imm(addr), 0x0C, 0x70, 0x0D, 0x0B.
- R7: Command code 2 (stack pointer read) issues 0x02, 0x0B, 0x0D. `core_tos` is sampled in the last settle cycle of the 0x0B.
- R8: Command code 3 (set program counter) issues imm(addr), then 0x04.
- R9: Command code 4 (single step) issues the single opcode 0x00.
- R10: `cmd_ready` is 1 only while no command is in progress, and `cmd_valid` has no effect while it is 0. After the last settle cycle of a command, `rsp_valid` is 1 for exactly one cycle. `rsp_data` then holds the most recent `core_tos` sample, and commands that take no sample leave it unchanged.
- R11: For codes 0 and 1, `core_sp` is captured in the last settle cycle of the first opcode and compared in the last settle cycle of the final opcode. If they differ, `sp_err` becomes 1 and stays 1 until reset.
- R12: Command codes 5 to 7 issue a single 0x0B and complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted when valid |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 32 | Address or program-counter target |
| cmd_data | input | 32 | Write data |
| emu_req | output | 1 | Emulation request to the core |
| emu_ack | input | 1 | Core acknowledges emulation |
| emu_rdy | input | 1 | Core ready for the next opcode |
| emu_ir | output | 8 | Emulation instruction |
| emu_exec | output | 1 | Single-cycle execute strobe |
| core_tos | input | 32 | Core top-of-stack debug value |
| core_sp | input | 32 | Core stack pointer debug value |
| rsp_valid | output | 1 | Command completed |
| rsp_data | output | 32 | Last sampled top-of-stack value |
| sp_err | output | 1 | Sticky stack-pointer mismatch |

## Verification
The stack-pointer mismatch cannot happen with a well-behaved core. The stimulus therefore changes `core_sp` partway through a memory read, after the capture cycle and before the final compare. The bench then checks that the flag survives a later clean command. A second hard case is a core that drops `emu_rdy` between opcodes. A ready pattern that keeps toggling during a read sequence forces the sequencer to wait at many opcode boundaries. The busy-time command offer is made long enough to overlap several settle intervals, so a sequencer that accepted it would corrupt the running opcode stream.

// File: rtl/dbg_opseq_pkg.sv
package dbg_opseq_pkg;

  localparam int WORD_W = 32;
  localparam int OP_W   = 8;
  localparam int STEP_W = 4;

  // command codes
  localparam logic [2:0] CMD_MRD   = 3'd0;
  localparam logic [2:0] CMD_MWR   = 3'd1;
  localparam logic [2:0] CMD_SPRD  = 3'd2;
  localparam logic [2:0] CMD_SETPC = 3'd3;
  localparam logic [2:0] CMD_STEP  = 3'd4;

  // short opcodes: 4-bit zero prefix plus sub-code
  localparam logic [OP_W-1:0] OP_BREAK  = 8'h00;
  localparam logic [OP_W-1:0] OP_PUSHSP = 8'h02;
  localparam logic [OP_W-1:0] OP_POPPC  = 8'h04;
  localparam logic [OP_W-1:0] OP_LOAD   = 8'h08;
  localparam logic [OP_W-1:0] OP_NOP    = 8'h0B;
  localparam logic [OP_W-1:0] OP_STORE  = 8'h0C;
  localparam logic [OP_W-1:0] OP_POPSP  = 8'h0D;
  localparam logic [2:0]      LDSP_PFX  = 3'b011;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_LOAD, S_STRB, S_SETL
  } seq_state_e;

  typedef struct packed {
    logic [OP_W-1:0] op;
    logic            last;
    logic            sample;
    logic            cap_sp;
    logic            chk_sp;
  } step_t;

  // immediate chunk k (0 = most significant) of a 32-bit word
  function automatic logic [OP_W-1:0] imm_chunk(input logic [WORD_W-1:0] v,
                                                input logic [2:0] k);
    logic [WORD_W-1:0] s;
    s = v >> (28 - 7 * int'(k));
    return {1'b1, s[6:0]};
  endfunction

  function automatic logic [OP_W-1:0] ldsp(input logic [4:0] off);
    return {LDSP_PFX, off};
  endfunction

endpackage

// File: rtl/dbg_opseq_prog.sv
module dbg_opseq_prog
  import dbg_opseq_pkg::*;
(
  input  logic [2:0]        cmd,
  input  logic [STEP_W-1:0] step,
  input  logic [WORD_W-1:0] addr,
  input  logic [WORD_W-1:0] data,
  output step_t             st
);

  always_comb begin
    st      = '0;
    st.op   = OP_NOP;
    st.last = 1'b1;
    unique case (cmd)
      CMD_MRD: begin
        st.last = 1'b0;
        if (step == 4'd0) begin
          st.op = OP_PUSHSP; st.cap_sp = 1'b1;
        end else if (step <= 4'd5) begin
          st.op = imm_chunk(addr, 3'(step - 4'd1));
        end else if (step == 4'd6) begin
          st.op = OP_LOAD;
        end else if (step == 4'd7) begin
          st.op = OP_NOP; st.sample = 1'b1;
        end else if (step == 4'd8) begin
          st.op = ldsp(5'h11);
        end else if (step == 4'd9) begin
          st.op = OP_POPSP;
        end else begin
          st.op = OP_NOP; st.chk_sp = 1'b1; st.last = 1'b1;
        end
      end
      CMD_MWR: begin
        st.last = 1'b0;
        if (step == 4'd0) begin
          st.op = OP_PUSHSP; st.cap_sp = 1'b1;
        end else if (step <= 4'd5) begin
          st.op = imm_chunk(data, 3'(step - 4'd1));
        end else if (step == 4'd6) begin
          st.op = OP_NOP;
        end else if (step <= 4'd11) begin
          st.op = imm_chunk(addr, 3'(step - 4'd7));
        end else if (step == 4'd12) begin
          st.op = OP_STORE;
        end else if (step == 4'd13) begin
          st.op = ldsp(5'h10);
        end else if (step == 4'd14) begin
          st.op = OP_POPSP;
        end else begin
          st.op = OP_NOP; st.chk_sp = 1'b1; st.last = 1'b1;
        end
      end
      CMD_SPRD: begin
        st.last = 1'b0;
        if (step == 4'd0) begin
          st.op = OP_PUSHSP;
        end else if (step == 4'd1) begin
          st.op = OP_NOP; st.sample = 1'b1;
        end else begin
          st.op = OP_POPSP; st.last = 1'b1;
        end
      end
      CMD_SETPC: begin
        st.last = 1'b0;
        if (step <= 4'd4) begin
          st.op = imm_chunk(addr, 3'(step));
        end else begin
          st.op = OP_POPPC; st.last = 1'b1;
        end
      end
      CMD_STEP: begin
        st.op = OP_BREAK;
      end
      default: begin
        st.op = OP_NOP;
      end
    endcase
  end

endmodule

// File: rtl/dbg_opseq_settle.sv
module dbg_opseq_settle #(
  parameter int SETTLE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? CNT_INIT : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  assert_settle_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_INIT);

  assert_settle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/dbg_opseq_ctrl.sv
module dbg_opseq_ctrl
  import dbg_opseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              emu_ack,
  input  logic              emu_rdy,
  input  logic              settle_done,
  input  logic [OP_W-1:0]   st_op,
  input  logic              st_last,
  output logic              cmd_ready,
  output logic              emu_req,
  output logic              emu_exec,
  output logic [OP_W-1:0]   emu_ir,
  output logic              settle_load,
  output logic              step_end,
  output logic              rsp_valid,
  output logic [STEP_W-1:0] step,
  output logic [2:0]        cur_cmd,
  output logic [WORD_W-1:0] cur_addr,
  output logic [WORD_W-1:0] cur_data
);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [OP_W-1:0]   ir_q, ir_d;
  logic              req_q, req_d;
  logic              rspv_q, rspv_d;
  logic [2:0]        cmd_q;
  logic [WORD_W-1:0] addr_q, data_q;
  logic              cmd_en;

  always_comb begin
    state_d     = state_q;
    step_d      = step_q;
    ir_d        = ir_q;
    req_d       = req_q;
    rspv_d      = 1'b0;
    cmd_en      = 1'b0;
    settle_load = 1'b0;
    step_end    = 1'b0;
    unique case (state_q)
      S_IDLE: if (cmd_valid) begin
        cmd_en  = 1'b1;
        step_d  = '0;
        req_d   = 1'b1;
        state_d = S_WAIT;
      end
      S_WAIT: if (emu_rdy && emu_ack) begin
        ir_d    = st_op;
        state_d = S_LOAD;
      end
      S_LOAD: state_d = S_STRB;
      S_STRB: begin
        settle_load = 1'b1;
        state_d     = S_SETL;
      end
      S_SETL: if (settle_done) begin
        step_end = 1'b1;
        if (st_last) begin
          ir_d    = OP_NOP;
          rspv_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          step_d  = step_q + 1'b1;
          state_d = S_WAIT;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      ir_q    <= OP_NOP;
      req_q   <= 1'b0;
      rspv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      ir_q    <= ir_d;
      req_q   <= req_d;
      rspv_q  <= rspv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (cmd_en) begin
      cmd_q  <= cmd_op;
      addr_q <= cmd_addr;
      data_q <= cmd_data;
    end
  end

  assign cmd_ready = (state_q == S_IDLE);
  assign emu_exec  = (state_q == S_STRB);
  assign emu_ir    = ir_q;
  assign emu_req   = req_q;
  assign rsp_valid = rspv_q;
  assign step      = step_q;
  assign cur_cmd   = cmd_q;
  assign cur_addr  = addr_q;
  assign cur_data  = data_q;

  assert_idle_nop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (emu_ir == OP_NOP));

  assert_exec_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    emu_exec |=> !emu_exec);

  assert_ir_before_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    emu_exec |-> $stable(emu_ir));

  assert_ir_held_settle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SETL) |-> $stable(emu_ir));

  assert_req_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(emu_req));

  assert_ir_after_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(emu_ir) && !cmd_ready) |-> $past(emu_rdy && emu_ack));

  assert_exec_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    emu_exec |-> emu_req);

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (cmd_ready && !$past(rsp_valid)));

endmodule

// File: rtl/dbg_opseq_capture.sv
module dbg_opseq_capture
  import dbg_opseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_end,
  input  logic              sample,
  input  logic              cap_sp,
  input  logic              chk_sp,
  input  logic [WORD_W-1:0] core_tos,
  input  logic [WORD_W-1:0] core_sp,
  output logic [WORD_W-1:0] rsp_data,
  output logic              sp_err
);

  logic [WORD_W-1:0] sp_save_q, rsp_q;
  logic              err_q;
  logic              sp_en, rsp_en, err_set;

  always_comb begin
    sp_en   = step_end & cap_sp;
    rsp_en  = step_end & sample;
    err_set = step_end & chk_sp & (core_sp != sp_save_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_save_q <= '0;
    else if (sp_en) sp_save_q <= core_sp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_q <= '0;
    else if (rsp_en) rsp_q <= core_tos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  assign rsp_data = rsp_q;
  assign sp_err   = err_q;

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sp_err |=> sp_err);

  assert_rsp_only_on_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_end && sample) |=> $stable(rsp_data));

endmodule

// File: rtl/dbg_opseq.sv
module dbg_opseq
  import dbg_opseq_pkg::*;
#(
  parameter int SETTLE_CYC = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_op,
  input  logic [31:0] cmd_addr,
  input  logic [31:0] cmd_data,
  output logic        emu_req,
  input  logic        emu_ack,
  input  logic        emu_rdy,
  output logic [7:0]  emu_ir,
  output logic        emu_exec,
  input  logic [31:0] core_tos,
  input  logic [31:0] core_sp,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        sp_err
);

  step_t             st;
  logic [STEP_W-1:0] step;
  logic [2:0]        cur_cmd;
  logic [WORD_W-1:0] cur_addr, cur_data;
  logic              settle_load, settle_done, step_end;

  dbg_opseq_prog u_prog (
    .cmd  (cur_cmd),
    .step (step),
    .addr (cur_addr),
    .data (cur_data),
    .st   (st)
  );

  dbg_opseq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (settle_load),
    .done  (settle_done)
  );

  dbg_opseq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data),
    .emu_ack     (emu_ack),
    .emu_rdy     (emu_rdy),
    .settle_done (settle_done),
    .st_op       (st.op),
    .st_last     (st.last),
    .cmd_ready   (cmd_ready),
    .emu_req     (emu_req),
    .emu_exec    (emu_exec),
    .emu_ir      (emu_ir),
    .settle_load (settle_load),
    .step_end    (step_end),
    .rsp_valid   (rsp_valid),
    .step        (step),
    .cur_cmd     (cur_cmd),
    .cur_addr    (cur_addr),
    .cur_data    (cur_data)
  );

  dbg_opseq_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_end (step_end),
    .sample   (st.sample),
    .cap_sp   (st.cap_sp),
    .chk_sp   (st.chk_sp),
    .core_tos (core_tos),
    .core_sp  (core_sp),
    .rsp_data (rsp_data),
    .sp_err   (sp_err)
  );

  assert_cmd_ignored_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && !rsp_valid) |=> $stable(cur_cmd));

endmodule

// File: tb/test_dbg_opseq.sv
module test_dbg_opseq;

  localparam int SETTLE = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_addr, cmd_data;
  logic        emu_req, emu_ack, emu_rdy;
  logic [7:0]  emu_ir;
  logic        emu_exec;
  logic [31:0] core_tos, core_sp;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        sp_err;

  always #4 clk = ~clk;

  assign emu_ack = emu_req;

  dbg_opseq #(.SETTLE_CYC(SETTLE)) i_dbg_opseq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .emu_req(emu_req), .emu_ack(emu_ack), .emu_rdy(emu_rdy),
    .emu_ir(emu_ir), .emu_exec(emu_exec), .core_tos(core_tos),
    .core_sp(core_sp), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sp_err(sp_err)
  );

  int    nvec = 0;
  int    nfail = 0;
  string cur_req = "R1";
  bit    rdy_wiggle = 1'b0;
  bit    rdy_level = 1'b0;
  int    wig_cnt = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // ready pattern seen by the sequencer
  always @(negedge clk) begin
    wig_cnt++;
    emu_rdy = rdy_wiggle ? ((wig_cnt % 7) > 2) : rdy_level;
  end

  // immediate chunk as written in R4
  function automatic logic [7:0] imm_b(input logic [31:0] v, input int k);
    case (k)
      0:       return {4'b1000, v[31:28]};
      1:       return {1'b1, v[27:21]};
      2:       return {1'b1, v[20:14]};
      3:       return {1'b1, v[13:7]};
      default: return {1'b1, v[6:0]};
    endcase
  endfunction

  // flags: 1 = sample tos, 2 = capture sp, 4 = compare sp
  function automatic void build(input logic [2:0] op, input logic [31:0] a,
                                input logic [31:0] d,
                                ref logic [7:0] q[$], ref int f[$]);
    q.delete(); f.delete();
    case (op)
      3'd0: begin
        q.push_back(8'h02); f.push_back(2);
        for (int k = 0; k < 5; k++) begin q.push_back(imm_b(a, k)); f.push_back(0); end
        q.push_back(8'h08); f.push_back(0);
        q.push_back(8'h0B); f.push_back(1);
        q.push_back(8'h71); f.push_back(0);
        q.push_back(8'h0D); f.push_back(0);
        q.push_back(8'h0B); f.push_back(4);
      end
      3'd1: begin
        q.push_back(8'h02); f.push_back(2);
        for (int k = 0; k < 5; k++) begin q.push_back(imm_b(d, k)); f.push_back(0); end
        q.push_back(8'h0B); f.push_back(0);
        for (int k = 0; k < 5; k++) begin q.push_back(imm_b(a, k)); f.push_back(0); end
        q.push_back(8'h0C); f.push_back(0);
        q.push_back(8'h70); f.push_back(0);
        q.push_back(8'h0D); f.push_back(0);
        q.push_back(8'h0B); f.push_back(4);
      end
      3'd2: begin
        q.push_back(8'h02); f.push_back(0);
        q.push_back(8'h0B); f.push_back(1);
        q.push_back(8'h0D); f.push_back(0);
      end
      3'd3: begin
        for (int k = 0; k < 5; k++) begin q.push_back(imm_b(a, k)); f.push_back(0); end
        q.push_back(8'h04); f.push_back(0);
      end
      3'd4: begin q.push_back(8'h00); f.push_back(0); end
      default: begin q.push_back(8'h0B); f.push_back(0); end
    endcase
  endfunction

  // behavioural reference, advanced on every rising edge
  logic [7:0]  mq[$];
  int          mf[$];
  int          ph;
  int          cnt;
  logic [7:0]  m_ir;
  bit          m_req, m_rspv, m_err;
  logic [31:0] m_rsp, m_spsave;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; cnt = 0; m_ir = 8'h0B; m_req = 0; m_rspv = 0; m_err = 0;
      m_rsp = '0; m_spsave = '0; mq.delete(); mf.delete();
    end else begin
      m_rspv = 0;
      case (ph)
        0: if (cmd_valid) begin
          build(cmd_op, cmd_addr, cmd_data, mq, mf);
          m_req = 1; ph = 1;
        end
        1: if (emu_rdy && m_req) begin m_ir = mq[0]; ph = 2; end
        2: ph = 3;
        3: begin ph = 4; cnt = SETTLE; end
        default: begin
          cnt--;
          if (cnt == 0) begin
            if (mf[0] & 1) m_rsp = core_tos;
            if (mf[0] & 2) m_spsave = core_sp;
            if ((mf[0] & 4) && core_sp != m_spsave) m_err = 1;
            void'(mq.pop_front());
            void'(mf.pop_front());
            if (mq.size() == 0) begin
              ph = 0; m_ir = 8'h0B; m_rspv = 1;
            end else ph = 1;
          end
        end
      endcase
    end
  end

  // cycle compare and executed-opcode log
  logic [7:0] seen[$];

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      nvec++;
      chk(cur_req, "emu_ir", emu_ir, m_ir);
      chk("R2", "emu_exec", emu_exec, (ph == 3));
      chk("R10", "cmd_ready", cmd_ready, (ph == 0));
      chk("R3", "emu_req", emu_req, m_req);
      chk("R10", "rsp_valid", rsp_valid, m_rspv);
      chk("R10", "rsp_data", rsp_data, m_rsp);
      chk("R11", "sp_err", sp_err, m_err);
      if (emu_exec) seen.push_back(emu_ir);
    end
  end

  task automatic run(input logic [2:0] op, input logic [31:0] a,
                     input logic [31:0] d, input string tag);
    logic [7:0] eq[$];
    int         ef[$];
    cur_req = tag;
    seen.delete();
    build(op, a, d, eq, ef);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (rsp_valid) break;
    end
    chk(tag, "opcode count", seen.size(), eq.size());
    for (int i = 0; i < eq.size() && i < seen.size(); i++)
      chk(tag, "opcode stream", seen[i], eq[i]);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL R10 watchdog act=hung exp=complete");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
    core_tos = '0; core_sp = 32'h0000_1000;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset emu_ir", emu_ir, 8'h0B);
    chk("R1", "reset emu_exec", emu_exec, 0);
    chk("R1", "reset emu_req", emu_req, 0);
    chk("R1", "reset cmd_ready", cmd_ready, 1);
    chk("R1", "reset rsp_valid", rsp_valid, 0);
    chk("R1", "reset sp_err", sp_err, 0);
    chk("R1", "reset rsp_data", rsp_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 single step with the core not yet ready (R3)
    fork
      run(3'd4, '0, '0, "R9");
      begin
        repeat (5) @(negedge clk);
        chk("R3", "req while waiting", emu_req, 1);
        chk("R3", "ir held while not ready", emu_ir, 8'h0B);
        rdy_level = 1'b1;
      end
    join

    // R5 memory read, R4 chunking
    core_tos = 32'hCAFE_F00D;
    run(3'd0, 32'h0000_08D8, '0, "R5");
    chk("R10", "read result", rsp_data, 32'hCAFE_F00D);
    chk("R11", "clean read no error", sp_err, 0);

    // R6 memory write with a command offered while busy (R10)
    core_tos = 32'h1111_2222;
    fork
      run(3'd1, 32'h0000_08D8, 32'hDEAD_BEEF, "R6");
      begin
        repeat (20) @(negedge clk);
        cmd_valid = 1'b1;
        repeat (30) @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    chk("R10", "write leaves rsp_data", rsp_data, 32'hCAFE_F00D);

    // R7 stack pointer read
    core_tos = 32'h0001_FFF0;
    run(3'd2, '0, '0, "R7");
    chk("R7", "sp read result", rsp_data, 32'h0001_FFF0);

    // R8 set program counter, high nibble and all-ones chunks (R4)
    run(3'd3, 32'h8000_0000, '0, "R8");
    run(3'd3, 32'h7FFF_FFFF, '0, "R4");

    // R3 read with a ready line that keeps dropping
    rdy_wiggle = 1'b1;
    core_tos = 32'h5A5A_A5A5;
    run(3'd0, 32'h1234_5678, '0, "R5");
    rdy_wiggle = 1'b0;
    chk("R10", "read under ready gaps", rsp_data, 32'h5A5A_A5A5);

    // R11 stack pointer disturbed mid-read
    fork
      run(3'd0, 32'h0000_0040, '0, "R5");
      begin
        repeat (40) @(negedge clk);
        core_sp = 32'h0000_0FFC;
      end
    join
    chk("R11", "mismatch raises flag", sp_err, 1);
    core_sp = 32'h0000_1000;
    run(3'd4, '0, '0, "R9");
    chk("R11", "flag sticky", sp_err, 1);

    // R12 unused codes
    run(3'd6, 32'hFFFF_FFFF, '0, "R12");
    run(3'd7, '0, '0, "R12");
    chk("R12", "idle after unused code", cmd_ready, 1);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule